// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning

This block is a watchdog that runs from a slow base tick of roughly 128 kHz, supplied as a one-cycle pulse on `tick_in` in the system clock domain. Each base tick first passes through a divider whose ratio is any odd value from 1 to 15. The divided tick then advances a period counter. When the counter reaches the selected period N, the block sets an early-warning flag if early warning is enabled. The counter keeps running. When it reaches 2N, the final time-out fires. Depending on the configured mode, that time-out either sets an interrupt flag or emits a one-cycle reset request. After the final time-out the counter wraps to zero and counting starts again.

Software restarts both counting stages with a `kick` pulse. Settings are loaded through a register-style port: divider select, prescale select, early-warning enable and final-time-out mode are all written together on `cfg_we`. Both flags are write-one-to-clear. The early-warning flag is also cleared by the interrupt-acknowledge input. One interrupt line carries both sources, and it is gated by a global interrupt enable.

There is no data stream through this block. All pins are plain control and status signals, so no valid/ready handshake or back-pressure applies.

Top module: `wdt_early_warn`

## Requirements
- R1: The divider select code c (0..7) sets the divide ratio to 2c+1. One divided tick occurs on every (2c+1)-th base tick after a kick.
- R2: Prescale code p sets the early-warning period N = 2^(BASE_EXP+p) divided ticks, with BASE_EXP = 11 by default. Codes above 9 act as code 9.
- R3: The final time-out fires on divided tick 2N after a kick. The counter then wraps to zero, so the next early warning comes N divided ticks after the final time-out.
- R4: The early-warning flag (flag bit 0) is set at the early-warning expiry only while the early-warning enable is set.
- R5: The early-warning flag is cleared by `irq_ack` or by a flag write with bit 0 set. A write with bit 0 at zero leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R6: `irq` is high exactly when `glob_ie` is high and either (early-warning enable and early-warning flag) or the final flag is set.
- R7: With `cfg_fin_reset`=0, the final time-out sets the final flag (flag bit 1) and `rst_req` stays low. With `cfg_fin_reset`=1, `rst_req` pulses high for exactly one cycle and the final flag is not set.
- R8: `kick` clears the divider and period counters, so both time-outs restart counting from zero.
- R9: After reset both flags, `irq` and `rst_req` are low. The configuration resets to ratio 1, code 0, early warning disabled and interrupt mode.
- R10: The final flag is cleared only by a flag write with bit 1 set. `irq_ack` does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Base tick pulse, one cycle wide |
| kick | input | 1 | Restart both counting stages |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_div_sel | input | 3 | Divider code, ratio 2c+1 |
| cfg_pre_sel | input | 4 | Prescale code, period 2^(BASE_EXP+p) |
| cfg_ew_en | input | 1 | Early-warning enable |
| cfg_fin_reset | input | 1 | Final time-out mode: 1 = reset request, 0 = interrupt |
| glob_ie | input | 1 | Global interrupt enable |
| flag_we | input | 1 | Flag write strobe (write-one-to-clear) |
| flag_wdata | input | 2 | Bit 0 = early-warning flag, bit 1 = final flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the early-warning flag |
| ew_flag | output | 1 | Early-warning flag |
| fin_flag | output | 1 | Final time-out interrupt flag |
| irq | output | 1 | Shared watchdog interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest situations to reach from the ports are the longest periods, meaning the reserved prescale codes that must behave like the largest one, and a flag clear that lands in the very cycle the hardware sets the flag. The bench builds the block with a small base exponent and holds the base tick high every cycle. This makes even the largest period reachable in a few thousand cycles, and each expiry lands on an edge count from the kick that the bench computes exactly. The clear write is then driven on the negative edge just before the computed expiry edge, so that the set and the clear meet at the same clock edge.

// File: rtl/wdt_ew_pkg.sv
package wdt_ew_pkg;

  typedef enum logic {
    FIN_IRQ   = 1'b0,
    FIN_RESET = 1'b1
  } fin_mode_e;

  localparam int FLAG_EW_BIT  = 0;
  localparam int FLAG_FIN_BIT = 1;
  localparam int FLAG_W       = 2;

endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);

  localparam int CNT_W = SEL_W + 1;

  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] ratio_m1;
  logic             hit;

  // ratio minus one is 2*sel
  assign ratio_m1 = {sel, 1'b0};
  assign hit      = tick_in && !kick && (dcnt >= ratio_m1);
  assign div_tick = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (kick) begin
      dcnt <= '0;
    end else if (tick_in) begin
      if (hit) dcnt <= '0;
      else     dcnt <= dcnt + 1'b1;
    end
  end

  AST_DIV_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !div_tick);  // R8

endmodule

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9,
  parameter int PRE_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             div_tick,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             ew_hit,
  output logic             fin_hit
);

  localparam int CNT_W = BASE_EXP + MAX_CODE + 1;
  localparam int SH_W  = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_next;
  logic [PRE_W-1:0] eff_code;
  logic [SH_W-1:0]  shamt;
  logic [CNT_W:0]   ew_lim;
  logic [CNT_W:0]   fin_lim;

  // reserved codes fold onto the largest period
  assign eff_code = (pre_sel > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : pre_sel;
  assign shamt    = SH_W'(BASE_EXP) + SH_W'(eff_code);
  assign ew_lim   = (CNT_W + 1)'(1) << shamt;
  assign fin_lim  = ew_lim << 1;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign ew_hit   = div_tick && !kick && (cnt_next == ew_lim);
  assign fin_hit  = div_tick && !kick && (cnt_next >= fin_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (kick) begin
      cnt <= '0;
    end else if (div_tick) begin
      if (fin_hit) cnt <= '0;
      else         cnt <= cnt_next[CNT_W-1:0];
    end
  end

  AST_KICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !(ew_hit || fin_hit));  // R8
  AST_STAGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_hit |-> !ew_hit);  // R3

endmodule

// File: rtl/wdt_flags.sv
module wdt_flags
  import wdt_ew_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ew_hit,
  input  logic              fin_hit,
  input  logic              ew_en,
  input  fin_mode_e         fin_mode,
  input  logic              ack,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  output logic              ew_flag,
  output logic              fin_flag,
  output logic              rst_req
);

  logic ew_set, ew_clr, fin_set, fin_clr;

  assign ew_set  = ew_hit && ew_en;
  assign ew_clr  = ack || (clr_we && clr_bits[FLAG_EW_BIT]);
  assign fin_set = fin_hit && (fin_mode == FIN_IRQ);
  assign fin_clr = clr_we && clr_bits[FLAG_FIN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ew_flag  <= 1'b0;
      fin_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (ew_set)      ew_flag <= 1'b1;
      else if (ew_clr) ew_flag <= 1'b0;
      if (fin_set)      fin_flag <= 1'b1;
      else if (fin_clr) fin_flag <= 1'b0;
      rst_req <= fin_hit && (fin_mode == FIN_RESET);
    end
  end

  AST_EW_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ew_flag) |-> $past(ew_en));  // R4
  AST_EW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ew_set |=> ew_flag);  // R5
  AST_EW_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ew_set) |=> !ew_flag);  // R5
  AST_FIN_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_flag && !fin_clr) |=> fin_flag);  // R10

endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
  import wdt_ew_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9,
  parameter int DIV_W    = 3,
  parameter int PRE_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             kick,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div_sel,
  input  logic [PRE_W-1:0] cfg_pre_sel,
  input  logic             cfg_ew_en,
  input  logic             cfg_fin_reset,
  input  logic             glob_ie,
  input  logic             flag_we,
  input  logic [1:0]       flag_wdata,
  input  logic             irq_ack,
  output logic             ew_flag,
  output logic             fin_flag,
  output logic             irq,
  output logic             rst_req
);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             ew_en_q;
  fin_mode_e        mode_q;
  logic             div_tick;
  logic             ew_hit;
  logic             fin_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_q   <= '0;
      ew_en_q <= 1'b0;
      mode_q  <= FIN_IRQ;
    end else if (cfg_we) begin
      div_q   <= cfg_div_sel;
      pre_q   <= cfg_pre_sel;
      ew_en_q <= cfg_ew_en;
      mode_q  <= cfg_fin_reset ? FIN_RESET : FIN_IRQ;
    end
  end

  wdt_tick_div #(.SEL_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .tick_in  (tick_in),
    .sel      (div_q),
    .div_tick (div_tick)
  );

  wdt_period_cnt #(.BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE), .PRE_W(PRE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .div_tick (div_tick),
    .pre_sel  (pre_q),
    .ew_hit   (ew_hit),
    .fin_hit  (fin_hit)
  );

  wdt_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ew_hit   (ew_hit),
    .fin_hit  (fin_hit),
    .ew_en    (ew_en_q),
    .fin_mode (mode_q),
    .ack      (irq_ack),
    .clr_we   (flag_we),
    .clr_bits (flag_wdata),
    .ew_flag  (ew_flag),
    .fin_flag (fin_flag),
    .rst_req  (rst_req)
  );

  assign irq = glob_ie && ((ew_en_q && ew_flag) || fin_flag);

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glob_ie);  // R6
  AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);  // R7
  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_flag) |-> !rst_req);  // R7

endmodule

// File: tb/wdt_early_warn_tb_top.sv
module wdt_early_warn_tb_top;

  localparam int BEXP = 4;
  localparam int N0   = 1 << BEXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b0, kick = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_div_sel = '0;
  logic [3:0] cfg_pre_sel = '0;
  logic cfg_ew_en = 1'b0, cfg_fin_reset = 1'b0, glob_ie = 1'b0;
  logic flag_we = 1'b0;
  logic [1:0] flag_wdata = '0;
  logic irq_ack = 1'b0;
  logic ew_flag, fin_flag, irq, rst_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdt_early_warn #(.BASE_EXP(BEXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .kick(kick), .cfg_we(cfg_we),
    .cfg_div_sel(cfg_div_sel), .cfg_pre_sel(cfg_pre_sel), .cfg_ew_en(cfg_ew_en),
    .cfg_fin_reset(cfg_fin_reset), .glob_ie(glob_ie), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .irq_ack(irq_ack), .ew_flag(ew_flag),
    .fin_flag(fin_flag), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic configure(input logic [2:0] d, input logic [3:0] p,
                           input logic en, input logic rmode);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div_sel = d; cfg_pre_sel = p;
    cfg_ew_en = en; cfg_fin_reset = rmode;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // kick and clear both flags on the same edge; ends just after that edge
  task automatic restart();
    @(negedge clk);
    kick = 1'b1; tick_in = 1'b1; flag_we = 1'b1; flag_wdata = 2'b11;
    @(negedge clk);
    kick = 1'b0; flag_we = 1'b0; flag_wdata = 2'b00;
  endtask

  task automatic t_reset_state();
    check(ew_flag, 1'b0, "R9 ew_flag after reset");
    check(fin_flag, 1'b0, "R9 fin_flag after reset");
    check(irq, 1'b0, "R9 irq after reset");
    check(rst_req, 1'b0, "R9 rst_req after reset");
  endtask

  task automatic t_early_basic();
    configure(3'd0, 4'd0, 1'b1, 1'b0);
    glob_ie = 1'b1;
    restart();
    advance(N0 - 1);
    check(ew_flag, 1'b0, "R2 ew_flag one tick before period");
    advance(1);
    check(ew_flag, 1'b1, "R2 ew_flag at period");
    check(irq, 1'b1, "R6 irq with gie and enable");
    glob_ie = 1'b0;
    #1;
    check(irq, 1'b0, "R6 irq masked by gie");
    glob_ie = 1'b1;
  endtask

  task automatic t_enable_off();
    configure(3'd0, 4'd0, 1'b0, 1'b0);
    restart();
    advance(N0);
    check(ew_flag, 1'b0, "R4 ew_flag stays low when disabled");
    check(irq, 1'b0, "R6 irq low when disabled");
  endtask

  task automatic t_final_irq_wrap();
    configure(3'd0, 4'd0, 1'b1, 1'b0);
    restart();
    advance(2 * N0 - 1);
    check(fin_flag, 1'b0, "R3 fin_flag before 2N");
    advance(1);
    check(fin_flag, 1'b1, "R7 fin_flag set at 2N in irq mode");
    check(rst_req, 1'b0, "R7 no rst_req in irq mode");
    check(irq, 1'b1, "R6 irq from final flag");
    flag_we = 1'b1; flag_wdata = 2'b01;
    advance(1);
    flag_we = 1'b0;
    irq_ack = 1'b1;
    advance(1);
    irq_ack = 1'b0;
    check(fin_flag, 1'b1, "R10 ack leaves final flag");
    flag_we = 1'b1; flag_wdata = 2'b10;
    advance(1);
    flag_we = 1'b0;
    check(fin_flag, 1'b0, "R10 write-one clears final flag");
    // now just after edge 2N+3; wrap puts next early warning at 3N
    advance(N0 - 4);
    check(ew_flag, 1'b0, "R3 ew_flag before 3N after wrap");
    advance(1);
    check(ew_flag, 1'b1, "R3 ew_flag at 3N after wrap");
  endtask

  task automatic t_reset_mode();
    configure(3'd0, 4'd0, 1'b1, 1'b1);
    restart();
    advance(2 * N0 - 1);
    check(rst_req, 1'b0, "R7 rst_req low before 2N");
    advance(1);
    check(rst_req, 1'b1, "R7 rst_req at 2N");
    check(fin_flag, 1'b0, "R7 fin_flag not set in reset mode");
    advance(1);
    check(rst_req, 1'b0, "R7 rst_req lasts one cycle");
  endtask

  task automatic t_divider();
    configure(3'd1, 4'd1, 1'b1, 1'b0);
    restart();
    advance(3 * 2 * N0 - 1);
    check(ew_flag, 1'b0, "R1 ratio 3 before period");
    advance(1);
    check(ew_flag, 1'b1, "R1 ratio 3 code 1 at period");
    configure(3'd7, 4'd0, 1'b1, 1'b0);
    restart();
    advance(15 * N0 - 1);
    check(ew_flag, 1'b0, "R1 ratio 15 before period");
    advance(1);
    check(ew_flag, 1'b1, "R1 ratio 15 at period");
  endtask

  task automatic t_reserved_code();
    configure(3'd0, 4'd12, 1'b1, 1'b0);
    restart();
    advance(N0 * 512 - 1);
    check(ew_flag, 1'b0, "R2 reserved code before code-9 period");
    advance(1);
    check(ew_flag, 1'b1, "R2 reserved code acts as code 9");
  endtask

  task automatic t_kick_restart();
    configure(3'd0, 4'd0, 1'b1, 1'b0);
    restart();
    advance(10);
    restart();
    advance(N0 - 1);
    check(ew_flag, 1'b0, "R8 kick restarts count");
    advance(1);
    check(ew_flag, 1'b1, "R8 ew_flag N after kick");
  endtask

  task automatic t_clear_rules();
    configure(3'd0, 4'd0, 1'b1, 1'b0);
    restart();
    advance(N0 - 1);
    flag_we = 1'b1; flag_wdata = 2'b01;
    advance(1);
    flag_we = 1'b0; flag_wdata = 2'b00;
    check(ew_flag, 1'b1, "R5 set wins over same-cycle clear");
    flag_we = 1'b1; flag_wdata = 2'b10;
    advance(1);
    flag_we = 1'b0;
    check(ew_flag, 1'b1, "R5 zero write leaves ew_flag");
    flag_we = 1'b1; flag_wdata = 2'b01;
    advance(1);
    flag_we = 1'b0;
    check(ew_flag, 1'b0, "R5 write-one clears ew_flag");
    restart();
    advance(N0);
    irq_ack = 1'b1;
    advance(1);
    irq_ack = 1'b0;
    check(ew_flag, 1'b0, "R5 ack clears ew_flag");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    advance(1);
    t_reset_state();
    t_early_basic();
    t_enable_off();
    t_final_irq_wrap();
    t_reset_mode();
    t_divider();
    t_reserved_code();
    t_kick_restart();
    t_clear_rules();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule